// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces memory addresses for indirect accesses that walk through circular buffers. It holds sixteen register sets. Each set has an index (the current pointer), a modify (a signed step), a length and a base. A second, complete copy of all sixteen sets sits in a shadow bank. A bank-select input picks which copy every access, write and read uses.

On each access the generator reports the chosen set's current index as the address. It then advances that index by the step. When the buffer length is non-zero, the new pointer is folded back inside the window that starts at the base and spans the length. A buffer may sit at any address, with no alignment or power-of-two limit on its base or length. In dual-transfer mode an access yields a pair of consecutive addresses, and the pointer moves by twice the step. Memory itself lies outside the block.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every index, modify, length and base register in both banks reads zero, the address-valid output is low and the primary bank (bank select 0) is active.
- R2: An access presented with accValid high at a clock edge makes addrValid high after that edge, with addr0 equal to the index the set held before the edge. addrValid is low after any edge without an access.
- R3: With a length of zero the set is linear: the index becomes index plus the signed modify, modulo 2^32.
- R4: With a non-zero length, a new pointer at or above base plus length is reduced by the length.
- R5: With a non-zero length, a new pointer below the base is raised by the length.
- R6: Writing the base field of a set also loads the index of that set with the same value at the same edge.
- R7: In dual-transfer mode (accDual high) the access reports addr1 = addr0 + 1 with addrDual high, and the index moves by twice the modify before the wrap of R4 and R5.
- R8: A change on bankSel takes effect from the next edge. An access or write at the edge where bankSel changes still uses the old bank. The two banks hold independent values.
- R9: Field codes are 0 for index, 1 for modify, 2 for length and 3 for base. rdData shows the selected field of the selected set in the active bank, combinationally.
- R10: When a write to the index or base of a set lands at the same edge as an access to that set, the written value is kept and the post-modify result is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankSel | input | 1 | Bank choice: 0 primary, 1 shadow; used from the next edge |
| wrEn | input | 1 | Register write strobe |
| wrField | input | 2 | Field to write (0 index, 1 modify, 2 length, 3 base) |
| wrSet | input | 4 | Set to write |
| wrData | input | 32 | Write value |
| rdField | input | 2 | Field to read |
| rdSet | input | 4 | Set to read |
| rdData | output | 32 | Read value from the active bank |
| accValid | input | 1 | Access request |
| accSet | input | 4 | Set used by the access |
| accDual | input | 1 | Dual-transfer access |
| addrValid | output | 1 | Address outputs hold a fresh access result |
| addrDual | output | 1 | The result is a pair |
| addr0 | output | 32 | First (or only) address |
| addr1 | output | 32 | Second address of a pair |

## Verification
Address results are registered, so addrValid, addr0, addr1 and addrDual belong to the edge that sampled accValid. The bench reads them one nanosecond after that edge. The updated index appears on rdData straight after the same edge, because readback is combinational. A bank switch changes what rdData shows only after the edge that registers bankSel. Every stimulus is applied just after a rising edge, and every check is made after the next edge has settled, so each result is read in the cycle in which it is due.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  localparam int ADDR_W = 32;
  localparam int SET_N = 16;
  localparam int SET_W = $clog2(SET_N);
  localparam int BANK_N = 2;

  typedef enum logic [1:0] {
    FLD_IDX  = 2'd0,
    FLD_MOD  = 2'd1,
    FLD_LEN  = 2'd2,
    FLD_BASE = 2'd3
  } field_e;

  typedef struct packed {
    logic              bank;
    logic              wrEn;
    field_e            wrField;
    logic [SET_W-1:0]  wrSet;
    logic [ADDR_W-1:0] wrData;
    logic              accEn;
    logic [SET_W-1:0]  accSet;
    logic              accDual;
  } strobe_t;
endpackage

// File: rtl/cbag_ctrl.sv
module cbag_ctrl
  import cbag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankSel,
  input  logic              wrEn,
  input  logic [1:0]        wrField,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              accValid,
  input  logic [SET_W-1:0]  accSet,
  input  logic              accDual,
  output strobe_t           st,
  output logic              addrValid,
  output logic              addrDual
);
  logic activeBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeBank <= 1'b0;
      addrValid  <= 1'b0;
      addrDual   <= 1'b0;
    end else begin
      activeBank <= bankSel;
      addrValid  <= accValid;
      addrDual   <= accValid & accDual;
    end
  end

  always_comb begin
    st.bank    = activeBank;
    st.wrEn    = wrEn;
    st.wrField = field_e'(wrField);
    st.wrSet   = wrSet;
    st.wrData  = wrData;
    st.accEn   = accValid;
    st.accSet  = accSet;
    st.accDual = accDual;
  end

  // R2
  acc_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> addrValid);

  // R8
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel != st.bank) |=> (st.bank == $past(bankSel)));
endmodule

// File: rtl/cbag_datapath.sv
module cbag_datapath
  import cbag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [1:0]        rdField,
  input  logic [SET_W-1:0]  rdSet,
  output logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr0,
  output logic [ADDR_W-1:0] addr1
);
  localparam int EW = ADDR_W + 2;

  logic [ADDR_W-1:0] idxReg  [BANK_N][SET_N];
  logic [ADDR_W-1:0] modReg  [BANK_N][SET_N];
  logic [ADDR_W-1:0] lenReg  [BANK_N][SET_N];
  logic [ADDR_W-1:0] baseReg [BANK_N][SET_N];

  logic [ADDR_W-1:0] curI, curM, curL, curB, nextIdx;
  logic signed [EW-1:0] iX, stepX, lX, bX, sumX, endX, adjX;

  assign curI = idxReg[st.bank][st.accSet];
  assign curM = modReg[st.bank][st.accSet];
  assign curL = lenReg[st.bank][st.accSet];
  assign curB = baseReg[st.bank][st.accSet];

  always_comb begin
    iX    = $signed({2'b00, curI});
    lX    = $signed({2'b00, curL});
    bX    = $signed({2'b00, curB});
    stepX = $signed({{2{curM[ADDR_W-1]}}, curM});
    if (st.accDual) stepX = stepX <<< 1;
    sumX = iX + stepX;
    endX = bX + lX;
    if (curL == '0)         adjX = sumX;
    else if (sumX >= endX)  adjX = sumX - lX;
    else if (sumX < bX)     adjX = sumX + lX;
    else                    adjX = sumX;
    nextIdx = adjX[ADDR_W-1:0];
  end

  always_comb begin
    unique case (field_e'(rdField))
      FLD_IDX:  rdData = idxReg[st.bank][rdSet];
      FLD_MOD:  rdData = modReg[st.bank][rdSet];
      FLD_LEN:  rdData = lenReg[st.bank][rdSet];
      default:  rdData = baseReg[st.bank][rdSet];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BANK_N; b++) begin
        for (int s = 0; s < SET_N; s++) begin
          idxReg[b][s]  <= '0;
          modReg[b][s]  <= '0;
          lenReg[b][s]  <= '0;
          baseReg[b][s] <= '0;
        end
      end
      addr0 <= '0;
      addr1 <= '0;
    end else begin
      if (st.accEn) begin
        idxReg[st.bank][st.accSet] <= nextIdx;
        addr0 <= curI;
        addr1 <= curI + ADDR_W'(1);
      end
      if (st.wrEn) begin
        unique case (st.wrField)
          FLD_IDX: idxReg[st.bank][st.wrSet] <= st.wrData;
          FLD_MOD: modReg[st.bank][st.wrSet] <= st.wrData;
          FLD_LEN: lenReg[st.bank][st.wrSet] <= st.wrData;
          default: begin
            baseReg[st.bank][st.wrSet] <= st.wrData;
            idxReg[st.bank][st.wrSet]  <= st.wrData;
          end
        endcase
      end
    end
  end

  logic wrHitsIdx, inWindow, smallStep;
  logic [EW-1:0] stepMag;
  logic [ADDR_W-1:0] linearNext;
  assign wrHitsIdx  = st.wrEn && (st.wrSet == st.accSet) &&
                      (st.wrField == FLD_IDX || st.wrField == FLD_BASE);
  assign stepMag    = stepX[EW-1] ? EW'(-stepX) : EW'(stepX);
  assign smallStep  = stepMag < EW'(curL);
  assign inWindow   = (curI >= curB) && (iX < endX) && (endX[EW-1:ADDR_W] == '0);
  assign linearNext = curI + (st.accDual ? (curM << 1) : curM);

  // R6
  base_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && st.wrField == FLD_BASE) |=>
      (idxReg[$past(st.bank)][$past(st.wrSet)] == $past(st.wrData)));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.accEn && curL == '0 && !wrHitsIdx) |=>
      (idxReg[$past(st.bank)][$past(st.accSet)] == $past(linearNext)));

  // R4
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.accEn && curL != '0 && inWindow && smallStep) |->
      (nextIdx >= curB && EW'(nextIdx) < EW'(endX)));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.accEn && st.wrEn && st.wrField == FLD_IDX && st.wrSet == st.accSet) |=>
      (idxReg[$past(st.bank)][$past(st.accSet)] == $past(st.wrData)));
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cbag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankSel,
  input  logic              wrEn,
  input  logic [1:0]        wrField,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdField,
  input  logic [SET_W-1:0]  rdSet,
  output logic [ADDR_W-1:0] rdData,
  input  logic              accValid,
  input  logic [SET_W-1:0]  accSet,
  input  logic              accDual,
  output logic              addrValid,
  output logic              addrDual,
  output logic [ADDR_W-1:0] addr0,
  output logic [ADDR_W-1:0] addr1
);
  strobe_t st;

  cbag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bankSel(bankSel),
    .wrEn(wrEn), .wrField(wrField), .wrSet(wrSet), .wrData(wrData),
    .accValid(accValid), .accSet(accSet), .accDual(accDual),
    .st(st), .addrValid(addrValid), .addrDual(addrDual)
  );

  cbag_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .rdField(rdField), .rdSet(rdSet), .rdData(rdData),
    .addr0(addr0), .addr1(addr1)
  );

  // R7
  dual_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrDual) |-> (addr1 == addr0 + 32'd1));
endmodule

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
  logic        clk = 1'b0;
  logic        rstN, bankSel, wrEn, accValid, accDual;
  logic [1:0]  wrField, rdField;
  logic [3:0]  wrSet, rdSet, accSet;
  logic [31:0] wrData, rdData, addr0, addr1;
  logic        addrValid, addrDual;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [1:0] F_I = 2'd0, F_M = 2'd1, F_L = 2'd2, F_B = 2'd3;

  always #2 clk = ~clk;

  circ_addr_gen dut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel),
    .wrEn(wrEn), .wrField(wrField), .wrSet(wrSet), .wrData(wrData),
    .rdField(rdField), .rdSet(rdSet), .rdData(rdData),
    .accValid(accValid), .accSet(accSet), .accDual(accDual),
    .addrValid(addrValid), .addrDual(addrDual), .addr0(addr0), .addr1(addr1)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic writeReg(input logic [3:0] s, input logic [1:0] f, input logic [31:0] d);
    wrEn = 1'b1; wrSet = s; wrField = f; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] s, input logic [1:0] f, output logic [31:0] d);
    rdSet = s; rdField = f;
    #0.5;
    d = rdData;
  endtask

  task automatic access(input logic [3:0] s, input bit dual);
    accValid = 1'b1; accSet = s; accDual = dual;
    tick();
    accValid = 1'b0; accDual = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    checkEq("R1 addrValid", {31'd0, addrValid}, 32'd0);
    readReg(4'd0, F_I, v);  checkEq("R1 idx set0", v, 32'd0);
    readReg(4'd5, F_L, v);  checkEq("R1 len set5", v, 32'd0);
    readReg(4'd15, F_B, v); checkEq("R1 base set15", v, 32'd0);
  endtask

  task automatic testWrites();
    logic [31:0] v;
    writeReg(4'd1, F_B, 32'd100);
    readReg(4'd1, F_I, v); checkEq("R6 base loads idx", v, 32'd100);
    readReg(4'd1, F_B, v); checkEq("R9 base field 3", v, 32'd100);
    writeReg(4'd1, F_M, 32'd7);
    writeReg(4'd1, F_L, 32'd10);
    readReg(4'd1, F_M, v); checkEq("R9 modify field 1", v, 32'd7);
    readReg(4'd1, F_L, v); checkEq("R9 length field 2", v, 32'd10);
  endtask

  task automatic testWrapUp();
    logic [31:0] v;
    access(4'd1, 1'b0);
    checkEq("R2 addrValid", {31'd0, addrValid}, 32'd1);
    checkEq("R2 addr0 first", addr0, 32'd100);
    readReg(4'd1, F_I, v); checkEq("R4 in-window step", v, 32'd107);
    access(4'd1, 1'b0);
    checkEq("R2 addr0 second", addr0, 32'd107);
    readReg(4'd1, F_I, v); checkEq("R4 upper wrap", v, 32'd104);
  endtask

  task automatic testWrapDown();
    logic [31:0] v;
    writeReg(4'd2, F_B, 32'd1003);
    writeReg(4'd2, F_L, 32'd20);
    writeReg(4'd2, F_M, 32'hFFFF_FFFB);
    access(4'd2, 1'b0);
    checkEq("R5 addr0", addr0, 32'd1003);
    readReg(4'd2, F_I, v); checkEq("R5 lower wrap", v, 32'd1018);
    access(4'd2, 1'b0);
    readReg(4'd2, F_I, v); checkEq("R5 negative step", v, 32'd1013);
  endtask

  task automatic testLinear();
    logic [31:0] v;
    writeReg(4'd3, F_B, 32'hFFFF_FFFE);
    writeReg(4'd3, F_M, 32'd3);
    access(4'd3, 1'b0);
    checkEq("R3 addr0", addr0, 32'hFFFF_FFFE);
    readReg(4'd3, F_I, v); checkEq("R3 linear modulo", v, 32'd1);
  endtask

  task automatic testDual();
    logic [31:0] v;
    writeReg(4'd4, F_B, 32'd50);
    writeReg(4'd4, F_L, 32'd8);
    writeReg(4'd4, F_M, 32'd3);
    access(4'd4, 1'b1);
    checkEq("R7 addrDual", {31'd0, addrDual}, 32'd1);
    checkEq("R7 addr0", addr0, 32'd50);
    checkEq("R7 addr1", addr1, 32'd51);
    readReg(4'd4, F_I, v); checkEq("R7 double step", v, 32'd56);
    access(4'd4, 1'b1);
    checkEq("R7 addr1 second", addr1, 32'd57);
    readReg(4'd4, F_I, v); checkEq("R7 double step wrap", v, 32'd54);
    access(4'd4, 1'b0);
    checkEq("R7 single clears addrDual", {31'd0, addrDual}, 32'd0);
  endtask

  task automatic testBank();
    logic [31:0] v;
    bankSel = 1'b1;
    access(4'd1, 1'b0);
    checkEq("R8 old bank at switch edge", addr0, 32'd104);
    readReg(4'd1, F_I, v); checkEq("R8 shadow idx starts zero", v, 32'd0);
    writeReg(4'd1, F_B, 32'd500);
    readReg(4'd1, F_I, v); checkEq("R8 shadow idx written", v, 32'd500);
    access(4'd1, 1'b0);
    checkEq("R8 shadow access", addr0, 32'd500);
    bankSel = 1'b0;
    readReg(4'd1, F_I, v); checkEq("R8 still shadow before edge", v, 32'd500);
    tick();
    readReg(4'd1, F_I, v); checkEq("R8 primary kept", v, 32'd101);
    readReg(4'd1, F_B, v); checkEq("R8 primary base kept", v, 32'd100);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    wrEn = 1'b1; wrSet = 4'd1; wrField = F_I; wrData = 32'd105;
    accValid = 1'b1; accSet = 4'd1; accDual = 1'b0;
    tick();
    wrEn = 1'b0; accValid = 1'b0;
    checkEq("R10 addr0 old idx", addr0, 32'd101);
    readReg(4'd1, F_I, v); checkEq("R10 write wins", v, 32'd105);
    tick();
    checkEq("R2 idle addrValid low", {31'd0, addrValid}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; bankSel = 1'b0; wrEn = 1'b0; accValid = 1'b0; accDual = 1'b0;
    wrField = 2'd0; rdField = 2'd0; wrSet = 4'd0; rdSet = 4'd0; accSet = 4'd0;
    wrData = 32'd0;
    testReset();
    testWrites();
    testWrapUp();
    testWrapDown();
    testLinear();
    testDual();
    testBank();
    testCollision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule